// File: doc/BRIEF.md
# FIFO Fill-Level Interrupt Generator

This block turns the fill-level flags of up to eight inbound (receive) and eight outbound (transmit) channel FIFOs into two combined interrupt requests, one for inbound events and one for outbound events. Each FIFO reports its condition through simple per-channel flags. Inbound FIFOs report "not empty" and "at least half full". Outbound FIFOs report "not full" and "at least half full". The block watches these flags for transitions, not for levels.

A 32-bit configuration register holds one enable bit and one mode bit for every channel. The mode bit selects which transition counts as an event for that channel. Events of all enabled channels in a direction are OR-combined. The result is registered into a single-cycle request pulse. A global enable input gates all requests. While the block is disabled, its per-channel history is held so that enabling it never produces a request for a condition that was already present. Clearing the interrupt on the CPU side is outside this block.

Top module: `fifo_lvl_irq`

## Requirements
- R1: After reset both request outputs are 0, and the configuration reads as zero, except that mode bits forced by R11 read as 1.
- R2: The configuration readback has inbound enables in bits 31:24, inbound modes in bits 23:16, outbound enables in bits 15:8 and outbound modes in bits 7:0. Bit n of each field belongs to channel n. A write with `cfg_we_i` high takes effect at the next clock edge.
- R3: Inbound channel in mode 0: a rise of its not-empty flag gives a pulse on `irq_rx_o` in the cycle after the rise.
- R4: Inbound channel in mode 1: a rise of its half-full flag gives the pulse instead. The not-empty flag is then ignored.
- R5: Outbound channel in mode 0: a rise of its not-full flag (full to not full) gives a pulse on `irq_tx_o` in the cycle after the rise.
- R6: Outbound channel in mode 1: a fall of its half-full flag (drops below half) gives the pulse instead.
- R7: A channel whose enable bit is 0 never contributes an event.
- R8: Events of all enabled channels in one direction are OR-ed into one request. Simultaneous events give a single one-cycle pulse.
- R9: While `enable_i` is 0 no request is raised in the following cycle. A condition that is already true when the block is enabled raises no request.
- R10: A condition that stays true gives no further request. Each request lasts exactly one cycle per transition.
- R11: With an inbound FIFO depth of 1, all implemented inbound mode bits read as 1 and act as 1. The same holds for the outbound side with an outbound depth of 1.
- R12: Configuration bits of channels above the implemented count read as 0. Such channels never raise a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Global enable of the block |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 32 | Configuration write data |
| cfg_rdata_o | output | 32 | Configuration readback |
| rx_nonempty_i | input | 8 | Per inbound channel: FIFO holds at least one word |
| rx_half_i | input | 8 | Per inbound channel: FIFO at least half full |
| tx_notfull_i | input | 8 | Per outbound channel: FIFO has at least one free entry |
| tx_half_i | input | 8 | Per outbound channel: FIFO at least half full |
| irq_rx_o | output | 1 | Inbound interrupt request pulse |
| irq_tx_o | output | 1 | Outbound interrupt request pulse |

## Verification
The assertions assume only that the flag inputs and the enable are known, synchronous values after reset. They do not assume any consistency between a channel's two flags, for example "half full" without "not empty". The stimulus changes every input at the falling clock edge. The random phase deliberately drives flag combinations that no real FIFO would produce. The properties on quiet inputs, the enable gate and the readback masks must hold for any such input pattern.

// File: rtl/fifo_irq_pkg.sv
package fifo_irq_pkg;
  localparam int CH_MAX      = 8;
  localparam int RX_EN_LSB   = 24;
  localparam int RX_MODE_LSB = 16;
  localparam int TX_EN_LSB   = 8;
  localparam int TX_MODE_LSB = 0;

  function automatic logic [CH_MAX-1:0] chan_mask(int num);
    logic [CH_MAX-1:0] m;
    for (int i = 0; i < CH_MAX; i++) m[i] = (i < num);
    return m;
  endfunction
endpackage

// File: rtl/fifo_irq_cfg.sv
module fifo_irq_cfg
  import fifo_irq_pkg::*;
#(
  parameter int NUM_RX   = 8,
  parameter int NUM_TX   = 8,
  parameter int RX_DEPTH = 16,
  parameter int TX_DEPTH = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [31:0]       wdata_i,
  output logic [CH_MAX-1:0] rx_en_o,
  output logic [CH_MAX-1:0] rx_mode_o,
  output logic [CH_MAX-1:0] tx_en_o,
  output logic [CH_MAX-1:0] tx_mode_o,
  output logic [31:0]       rdata_o
);
  localparam logic [CH_MAX-1:0] RX_MASK = chan_mask(NUM_RX);
  localparam logic [CH_MAX-1:0] TX_MASK = chan_mask(NUM_TX);
  localparam bit RX_FIX = (RX_DEPTH == 1);
  localparam bit TX_FIX = (TX_DEPTH == 1);

  logic [CH_MAX-1:0] rx_en_q, rx_mode_q, tx_en_q, tx_mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_en_q   <= '0;
      rx_mode_q <= '0;
      tx_en_q   <= '0;
      tx_mode_q <= '0;
    end else if (we_i) begin
      rx_en_q   <= wdata_i[RX_EN_LSB   +: CH_MAX];
      rx_mode_q <= wdata_i[RX_MODE_LSB +: CH_MAX];
      tx_en_q   <= wdata_i[TX_EN_LSB   +: CH_MAX];
      tx_mode_q <= wdata_i[TX_MODE_LSB +: CH_MAX];
    end
  end

  // unimplemented channels masked off; depth-1 FIFOs force mode 1
  assign rx_en_o   = rx_en_q & RX_MASK;
  assign tx_en_o   = tx_en_q & TX_MASK;
  assign rx_mode_o = RX_FIX ? RX_MASK : (rx_mode_q & RX_MASK);
  assign tx_mode_o = TX_FIX ? TX_MASK : (tx_mode_q & TX_MASK);

  always_comb begin
    rdata_o = '0;
    rdata_o[RX_EN_LSB   +: CH_MAX] = rx_en_o;
    rdata_o[RX_MODE_LSB +: CH_MAX] = rx_mode_o;
    rdata_o[TX_EN_LSB   +: CH_MAX] = tx_en_o;
    rdata_o[TX_MODE_LSB +: CH_MAX] = tx_mode_o;
  end
endmodule

// File: rtl/fifo_irq_edge.sv
module fifo_irq_edge
  import fifo_irq_pkg::*;
#(
  parameter int NUM_CH = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enable_i,
  input  logic [CH_MAX-1:0] en_i,
  input  logic [CH_MAX-1:0] mode_i,
  input  logic [CH_MAX-1:0] cond0_i,
  input  logic [CH_MAX-1:0] cond1_i,
  output logic              irq_o
);
  localparam logic [CH_MAX-1:0] CH_MASK = chan_mask(NUM_CH);

  logic [CH_MAX-1:0] hit;

  for (genvar ch = 0; ch < CH_MAX; ch++) begin : g_ch
    logic cond;
    logic prev_q;

    assign cond = mode_i[ch] ? cond1_i[ch] : cond0_i[ch];

    // held high while disabled: a condition already present at enable is not an event
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        prev_q <= 1'b1;
      else if (!enable_i) prev_q <= 1'b1;
      else                prev_q <= cond;
    end

    assign hit[ch] = CH_MASK[ch] & en_i[ch] & cond & ~prev_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_o <= 1'b0;
    else         irq_o <= enable_i & (|hit);
  end
endmodule

// File: rtl/fifo_lvl_irq.sv
module fifo_lvl_irq
  import fifo_irq_pkg::*;
#(
  parameter int NUM_RX   = 8,
  parameter int NUM_TX   = 8,
  parameter int RX_DEPTH = 16,
  parameter int TX_DEPTH = 16
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        enable_i,
  input  logic        cfg_we_i,
  input  logic [31:0] cfg_wdata_i,
  output logic [31:0] cfg_rdata_o,
  input  logic [7:0]  rx_nonempty_i,
  input  logic [7:0]  rx_half_i,
  input  logic [7:0]  tx_notfull_i,
  input  logic [7:0]  tx_half_i,
  output logic        irq_rx_o,
  output logic        irq_tx_o
);
  logic [CH_MAX-1:0] rx_en, rx_mode, tx_en, tx_mode;

  fifo_irq_cfg #(
    .NUM_RX(NUM_RX), .NUM_TX(NUM_TX), .RX_DEPTH(RX_DEPTH), .TX_DEPTH(TX_DEPTH)
  ) u_cfg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (cfg_we_i),
    .wdata_i  (cfg_wdata_i),
    .rx_en_o  (rx_en),
    .rx_mode_o(rx_mode),
    .tx_en_o  (tx_en),
    .tx_mode_o(tx_mode),
    .rdata_o  (cfg_rdata_o)
  );

  fifo_irq_edge #(.NUM_CH(NUM_RX)) u_rx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .enable_i(enable_i),
    .en_i    (rx_en),
    .mode_i  (rx_mode),
    .cond0_i (rx_nonempty_i),
    .cond1_i (rx_half_i),
    .irq_o   (irq_rx_o)
  );

  // outbound mode 1 watches for the fill level dropping below half
  fifo_irq_edge #(.NUM_CH(NUM_TX)) u_tx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .enable_i(enable_i),
    .en_i    (tx_en),
    .mode_i  (tx_mode),
    .cond0_i (tx_notfull_i),
    .cond1_i (~tx_half_i),
    .irq_o   (irq_tx_o)
  );
endmodule

// File: rtl/fifo_lvl_irq_chk.sv
module fifo_lvl_irq_chk
  import fifo_irq_pkg::*;
#(
  parameter int NUM_RX   = 8,
  parameter int NUM_TX   = 8,
  parameter int RX_DEPTH = 16,
  parameter int TX_DEPTH = 16
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        enable_i,
  input logic [31:0] cfg_rdata_o,
  input logic [7:0]  rx_nonempty_i,
  input logic [7:0]  rx_half_i,
  input logic [7:0]  tx_notfull_i,
  input logic [7:0]  tx_half_i,
  input logic        irq_rx_o,
  input logic        irq_tx_o
);
  localparam logic [CH_MAX-1:0] RXM = chan_mask(NUM_RX);
  localparam logic [CH_MAX-1:0] TXM = chan_mask(NUM_TX);
  localparam logic [31:0] LEGAL = {RXM, RXM, TXM, TXM};

  logic [1:0] age;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  p_gate_rx_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> !irq_rx_o);
  p_gate_tx_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> !irq_tx_o);

  p_no_en_rx_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_rdata_o[31:24] == 8'h00) |=> !irq_rx_o);
  p_no_en_tx_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_rdata_o[15:8] == 8'h00) |=> !irq_tx_o);

  p_unimpl_zero_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_rdata_o & ~LEGAL) == 32'h0);

  if (RX_DEPTH == 1) begin : g_rx_fix
    p_rx_mode_fixed_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cfg_rdata_o[23:16] == RXM);
  end
  if (TX_DEPTH == 1) begin : g_tx_fix
    p_tx_mode_fixed_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cfg_rdata_o[7:0] == TXM);
  end

  // no change on the inputs and configuration -> no new event (R10)
  p_quiet_rx_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age == 2'd3 && $past(rx_nonempty_i) == $past(rx_nonempty_i, 2) &&
     $past(rx_half_i) == $past(rx_half_i, 2) &&
     $past(cfg_rdata_o) == $past(cfg_rdata_o, 2)) |-> !irq_rx_o);
  p_quiet_tx_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age == 2'd3 && $past(tx_notfull_i) == $past(tx_notfull_i, 2) &&
     $past(tx_half_i) == $past(tx_half_i, 2) &&
     $past(cfg_rdata_o) == $past(cfg_rdata_o, 2)) |-> !irq_tx_o);
endmodule

bind fifo_lvl_irq fifo_lvl_irq_chk #(
  .NUM_RX(NUM_RX), .NUM_TX(NUM_TX), .RX_DEPTH(RX_DEPTH), .TX_DEPTH(TX_DEPTH)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .enable_i     (enable_i),
  .cfg_rdata_o  (cfg_rdata_o),
  .rx_nonempty_i(rx_nonempty_i),
  .rx_half_i    (rx_half_i),
  .tx_notfull_i (tx_notfull_i),
  .tx_half_i    (tx_half_i),
  .irq_rx_o     (irq_rx_o),
  .irq_tx_o     (irq_tx_o)
);

// File: tb/fifo_lvl_irq_tb.sv
module fifo_lvl_irq_tb;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [7:0]  rx_ne = '0, rx_hf = '0, tx_nf = '0, tx_hf = 8'hFF;
  logic [31:0] rd [2];
  logic        irqr [2];
  logic        irqt [2];

  int checks = 0, errors = 0;
  string phase = "R1";
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  // instance 0: defaults; instance 1: 4 inbound (depth 1), 6 outbound (depth 4)
  fifo_lvl_irq u_dut (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(en), .cfg_we_i(we), .cfg_wdata_i(wdata),
    .cfg_rdata_o(rd[0]), .rx_nonempty_i(rx_ne), .rx_half_i(rx_hf),
    .tx_notfull_i(tx_nf), .tx_half_i(tx_hf), .irq_rx_o(irqr[0]), .irq_tx_o(irqt[0]));

  fifo_lvl_irq #(.NUM_RX(4), .NUM_TX(6), .RX_DEPTH(1), .TX_DEPTH(4)) u_dut_small (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(en), .cfg_we_i(we), .cfg_wdata_i(wdata),
    .cfg_rdata_o(rd[1]), .rx_nonempty_i(rx_ne), .rx_half_i(rx_hf),
    .tx_notfull_i(tx_nf), .tx_half_i(tx_hf), .irq_rx_o(irqr[1]), .irq_tx_o(irqt[1]));

  function automatic logic [7:0] nmask(int n);
    logic [7:0] m;
    for (int i = 0; i < 8; i++) m[i] = (i < n);
    return m;
  endfunction

  // R2/R11/R12 readback rule for instance k
  function automatic logic [31:0] cfg_view(int k, logic [31:0] w);
    logic [7:0] irx, itx;
    irx = (k == 1) ? nmask(4) : nmask(8);
    itx = (k == 1) ? nmask(6) : nmask(8);
    return {w[31:24] & irx, (k == 1) ? irx : (w[23:16] & irx), w[15:8] & itx, w[7:0] & itx};
  endfunction

  // behavioural reference
  logic [31:0] m_cfg [2];
  logic [7:0]  m_prx [2], m_ptx [2];
  logic        m_irx [2], m_itx [2];
  logic        evr, evt, c;

  always @(posedge clk) begin
    for (int k = 0; k < 2; k++) begin
      if (!rst_n) begin
        m_cfg[k] = cfg_view(k, 32'h0);
        m_prx[k] = 8'hFF; m_ptx[k] = 8'hFF;
        m_irx[k] = 1'b0;  m_itx[k] = 1'b0;
      end else begin
        evr = 1'b0; evt = 1'b0;
        for (int ch = 0; ch < 8; ch++) begin
          c = m_cfg[k][16+ch] ? rx_hf[ch] : rx_ne[ch];
          if (m_cfg[k][24+ch] && c && !m_prx[k][ch]) evr = 1'b1;
          m_prx[k][ch] = en ? c : 1'b1;
          c = m_cfg[k][ch] ? !tx_hf[ch] : tx_nf[ch];
          if (m_cfg[k][8+ch] && c && !m_ptx[k][ch]) evt = 1'b1;
          m_ptx[k][ch] = en ? c : 1'b1;
        end
        m_irx[k] = en & evr;
        m_itx[k] = en & evt;
        if (we) m_cfg[k] = cfg_view(k, wdata);
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      for (int k = 0; k < 2; k++) begin
        checks++;
        if ({rd[k], irqr[k], irqt[k]} !== {m_cfg[k], m_irx[k], m_itx[k]}) begin
          errors++;
          $display("FAIL %s model inst%0d: actual cfg=%h rx=%b tx=%b expected cfg=%h rx=%b tx=%b",
                   phase, k, rd[k], irqr[k], irqt[k], m_cfg[k], m_irx[k], m_itx[k]);
        end
      end
    end
  end

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic write_cfg(logic [31:0] v);
    we = 1'b1; wdata = v;
    tick();
    we = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    finish_run();
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick();
    phase = "R1";
    chk("R1 cfg big", rd[0], 32'h0000_0000);
    chk("R1 cfg small", rd[1], 32'h000F_0000);
    chk("R1 irq", {30'h0, irqr[0], irqt[0]}, 32'h0);

    phase = "R2";
    write_cfg(32'hFFF0_FFF0);
    chk("R2 readback big", rd[0], 32'hFFF0_FFF0);
    chk("R12 readback small", rd[1], 32'h0F0F_3F30);
    en = 1'b1;
    tick(2);

    phase = "R3";
    rx_ne = 8'h02; tick();
    chk("R3 rx pulse", irqr[0], 1);
    chk("R11 small uses half flag", irqr[1], 0);
    tick();
    phase = "R10";
    chk("R10 no repeat", irqr[0], 0);
    tick(3);
    chk("R10 held level", irqr[0], 0);

    phase = "R4";
    rx_hf = 8'h20; rx_ne = 8'h22; tick();
    chk("R4 half rise", irqr[0], 1);
    tick();
    chk("R4 one cycle", irqr[0], 0);

    phase = "R5";
    tx_nf = 8'h01; tick();
    chk("R5 notfull rise", irqt[0], 1);
    tick();
    chk("R5 one cycle", irqt[0], 0);

    phase = "R6";
    tx_hf = 8'hBF; tick();
    chk("R6 below half", irqt[0], 1);
    tick();
    chk("R6 one cycle", irqt[0], 0);

    phase = "R7";
    write_cfg(32'h00F0_FFF0);
    rx_ne = 8'h26; tick();
    chk("R7 disabled channel", irqr[0], 0);
    write_cfg(32'hFFF0_FFF0);
    tick();
    chk("R7 re-enable no event", irqr[0], 0);

    phase = "R8";
    rx_ne = 8'h2F; tick();
    chk("R8 merged pulse", irqr[0], 1);
    tick();
    chk("R8 single cycle", irqr[0], 0);

    phase = "R9";
    en = 1'b0; tick();
    rx_hf = 8'hA0; tick();
    chk("R9 gated while disabled", irqr[0], 0);
    tick();
    en = 1'b1; tick();
    chk("R9 no event at enable", irqr[0], 0);
    tick();
    chk("R9 still quiet", irqr[0], 0);

    phase = "R11";
    write_cfg(32'hFF00_FFF0);
    chk("R11 forced modes", rd[1][23:16], 32'h0F);
    rx_hf = 8'hA1; tick();
    chk("R11 small half event", irqr[1], 1);
    chk("R11 big mode0 ignores half", irqr[0], 0);

    phase = "R12";
    write_cfg(32'hFFFF_FFFF);
    chk("R12 small mask", rd[1], 32'h0F0F_3F3F);
    tick();
    rx_hf = 8'hE1; tick();
    chk("R12 big ch6 event", irqr[0], 1);
    chk("R12 small ch6 absent", irqr[1], 0);

    phase = "R2..random";
    for (int i = 0; i < 3000; i++) begin
      rx_ne = $urandom; rx_hf = $urandom; tx_nf = $urandom; tx_hf = $urandom;
      en = ($urandom % 8) != 0;
      we = ($urandom % 16) == 0;
      wdata = $urandom;
      tick();
    end
    we = 1'b0;
    tick(2);
    finish_run();
  end
endmodule